// File: doc/BRIEF.md
# Receive Buffer Ring Fetcher

This block walks a circular table of receive-buffer descriptors kept in system memory. Each table entry is four 16-bit words giving a 32-bit buffer address and a 32-bit buffer length in words. The host programs four 16-bit ring pointers: ring start, exclusive ring end, read position and write position. It also programs one shared upper-address half that completes every memory address. On a fetch trigger the block reads the entry at the read position, one word at a time, over a request/valid memory port. It then loads the current buffer address and word-count registers, steps the read position and wraps it if needed.

The step size follows a data-width mode. In 16-bit mode the entry words sit 2 bytes apart and an entry occupies 8 bytes. In 32-bit mode each word sits in the low half of a 4-byte slot and an entry occupies 16 bytes. A fetch starts either from a fetch command or from the host clearing the ring-exhausted status with a write-one. When the read position catches up with the write position after a fetch, the exhausted status is raised together with a one-cycle event pulse. A finished fetch also clears a reception stall flag.

Top module: `rxr_fetch`

## Requirements
- R1: While reset is active and right after it, every ring pointer, the upper half, `buf_addr`, `buf_wcnt`, `busy`, `mem_req`, `exhausted`, `exhaust_evt` and `stall` are zero.
- R2: A host write with `cfg_we` uses `cfg_sel` to pick the target: 0 ring start, 1 ring end, 2 read position, 3 write position, 4 upper half. Codes 5 to 7 change nothing. Pointer writes clear bit 0 in 16-bit mode (`wide_mode`=0) and clear bits 1:0 in 32-bit mode. The upper half is stored as written.
- R3: A fetch issues exactly four reads, with no new request until the previous read has returned. Read k (k=0..3) is at address {upper, read position + 2k} in 16-bit mode and {upper, read position + 4k} in 32-bit mode. `mem_req` is high for one cycle per read.
- R4: `buf_addr` becomes {word1, word0} and `buf_wcnt` becomes {word3, word2}, in the cycle after the fourth word arrives, and at no other time.
- R5: In that same update the read position steps by 8 in 16-bit mode or by 16 in 32-bit mode, modulo 2^16.
- R6: If the stepped read position equals the ring end, the read position is reloaded from the ring start instead.
- R7: If the read position after stepping and wrapping equals the write position, `exhausted` goes high and `exhaust_evt` pulses for exactly one cycle. A fetch that ends elsewhere leaves `exhausted` unchanged.
- R8: A one-cycle `fetch_cmd` while idle makes `busy` high from the next cycle until the cycle of the update in R4.
- R9: A `stat_clr` pulse while `exhausted` is high clears it and starts a fetch. A `stat_clr` pulse while `exhausted` is low starts nothing.
- R10: `fetch_cmd` or `stat_clr` arriving while `busy` is high does not start an extra fetch.
- R11: `stall_set` sets `stall`. Each completed fetch clears it, and a simultaneous `stall_set` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 selects 32-bit descriptor layout |
| cfg_we | input | 1 | Host register write strobe |
| cfg_sel | input | 3 | Host register select (see R2) |
| cfg_wdata | input | 16 | Host write data |
| fetch_cmd | input | 1 | Fetch command pulse |
| stat_clr | input | 1 | Write-one clear of the exhausted status |
| stall_set | input | 1 | Marks the last buffer as full |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Fetch in progress |
| buf_addr | output | 32 | Current receive buffer address |
| buf_wcnt | output | 32 | Current receive buffer word count |
| ring_start | output | 16 | Ring start pointer |
| ring_end | output | 16 | Ring exclusive end pointer |
| ring_rd | output | 16 | Read position |
| ring_wr | output | 16 | Write position |
| ring_upper | output | 16 | Shared upper address half |
| exhausted | output | 1 | Ring-exhausted status |
| exhaust_evt | output | 1 | One-cycle pulse when exhausted is raised |
| stall | output | 1 | Reception stall flag |

## Verification
The fetch is exercised in 16-bit mode across three steps that run into the exclusive end. This separates a plain step from a wrap that lands on the write position, which then raises the exhausted status. It is then exercised in 32-bit mode with unaligned pointer writes, where the masking, the 4-byte word spacing and the 16-byte step all differ from the 16-bit case. Memory latency rotates between one and three cycles, so a sequencer that assumes a fixed return time diverges from the reference. Triggers are also sent while busy, a status clear is sent with the status low and high, and an unused select code is written. These show which stimuli must start a fetch and which must not.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int ENTRY_WORDS = 4;

  localparam logic [2:0] SEL_START = 3'd0;
  localparam logic [2:0] SEL_END   = 3'd1;
  localparam logic [2:0] SEL_RDP   = 3'd2;
  localparam logic [2:0] SEL_WRP   = 3'd3;
  localparam logic [2:0] SEL_UPPER = 3'd4;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_WAIT  = 2'd2
  } phase_e;
endpackage

// File: rtl/rxr_ptr_bank.sv
module rxr_ptr_bank
  import rxr_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int NWORDS = ENTRY_WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [PTR_W-1:0] wr_data_i,
  input  logic             adv_i,
  output logic [PTR_W-1:0] start_o,
  output logic [PTR_W-1:0] end_o,
  output logic [PTR_W-1:0] rd_o,
  output logic [PTR_W-1:0] wr_o,
  output logic [PTR_W-1:0] upper_o,
  output logic             hit_o
);
  localparam logic [PTR_W-1:0] STEP_NARROW = PTR_W'(NWORDS * 2);
  localparam logic [PTR_W-1:0] STEP_WIDE   = PTR_W'(NWORDS * 4);
  localparam logic [PTR_W-1:0] MASK_NARROW = ~PTR_W'(1);
  localparam logic [PTR_W-1:0] MASK_WIDE   = ~PTR_W'(3);

  logic [PTR_W-1:0] start_q, end_q, rd_q, wr_q, upper_q;
  logic [PTR_W-1:0] start_d, end_d, rd_d, wr_d, upper_d;
  logic [PTR_W-1:0] aligned, stepped, wrapped;

  always_comb begin
    aligned = wr_data_i & (wide_i ? MASK_WIDE : MASK_NARROW);
    stepped = rd_q + (wide_i ? STEP_WIDE : STEP_NARROW);
    wrapped = (stepped == end_q) ? start_q : stepped;
    hit_o   = (wrapped == wr_q);
  end

  always_comb begin
    start_d = start_q;
    end_d   = end_q;
    rd_d    = rd_q;
    wr_d    = wr_q;
    upper_d = upper_q;
    if (wr_en_i) begin
      case (wr_sel_i)
        SEL_START: start_d = aligned;
        SEL_END:   end_d   = aligned;
        SEL_RDP:   rd_d    = aligned;
        SEL_WRP:   wr_d    = aligned;
        SEL_UPPER: upper_d = wr_data_i;
        default:   ;
      endcase
    end
    if (adv_i) begin
      rd_d = wrapped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
      upper_q <= '0;
    end else begin
      start_q <= start_d;
      end_q   <= end_d;
      rd_q    <= rd_d;
      wr_q    <= wr_d;
      upper_q <= upper_d;
    end
  end

  assign start_o = start_q;
  assign end_o   = end_q;
  assign rd_o    = rd_q;
  assign wr_o    = wr_q;
  assign upper_o = upper_q;

  assert_rd_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == SEL_RDP && !adv_i && wide_i) |=> (rd_q[1:0] == 2'b00));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wr_en_i && start_q != end_q) |=> (rd_q != end_q));
endmodule

// File: rtl/rxr_seq.sv
module rxr_seq
  import rxr_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int WORD_W = 16,
  parameter int NWORDS = ENTRY_WORDS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     wide_i,
  input  logic [PTR_W-1:0]         base_i,
  input  logic [PTR_W-1:0]         upper_i,
  input  logic                     rvalid_i,
  input  logic [WORD_W-1:0]        rdata_i,
  output logic                     req_o,
  output logic [2*PTR_W-1:0]       addr_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [NWORDS*WORD_W-1:0] words_o
);
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  phase_e           ph_q, ph_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [PTR_W-1:0] offset;
  logic             take;

  always_comb begin
    offset = wide_i ? (PTR_W'(idx_q) << 2) : (PTR_W'(idx_q) << 1);
    addr_o = {upper_i, base_i + offset};
    req_o  = (ph_q == PH_ISSUE);
    busy_o = (ph_q != PH_IDLE);
    take   = (ph_q == PH_WAIT) && rvalid_i;
    done_o = take && (idx_q == LAST);
  end

  always_comb begin
    ph_d  = ph_q;
    idx_d = idx_q;
    case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          ph_d  = PH_ISSUE;
          idx_d = '0;
        end
      end
      PH_ISSUE: ph_d = PH_WAIT;
      PH_WAIT: begin
        if (rvalid_i) begin
          if (idx_q == LAST) begin
            ph_d = PH_IDLE;
          end else begin
            ph_d  = PH_ISSUE;
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
    end else begin
      ph_q  <= ph_d;
      idx_q <= idx_d;
    end
  end

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    if (k == NWORDS - 1) begin : g_live
      assign words_o[k*WORD_W +: WORD_W] = rdata_i;
    end else begin : g_held
      logic [WORD_W-1:0] cap_q;
      logic              cap_en;
      assign cap_en = take && (idx_q == IDX_W'(k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cap_q <= '0;
        end else if (cap_en) begin
          cap_q <= rdata_i;
        end
      end
      assign words_o[k*WORD_W +: WORD_W] = cap_q;
    end
  end

  assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  assert_first_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> req_o);
endmodule

// File: rtl/rxr_status.sv
module rxr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic hit_i,
  input  logic clr_i,
  input  logic stall_set_i,
  output logic exh_o,
  output logic evt_o,
  output logic stall_o
);
  logic exh_q, exh_d, evt_q, evt_d, stall_q, stall_d;

  always_comb begin
    exh_d = exh_q;
    if (clr_i && exh_q) exh_d = 1'b0;
    if (done_i && hit_i) exh_d = 1'b1;
    evt_d   = done_i && hit_i;
    stall_d = stall_q;
    if (done_i) stall_d = 1'b0;
    if (stall_set_i) stall_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exh_q   <= 1'b0;
      evt_q   <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      exh_q   <= exh_d;
      evt_q   <= evt_d;
      stall_q <= stall_d;
    end
  end

  assign exh_o   = exh_q;
  assign evt_o   = evt_q;
  assign stall_o = stall_q;

  assert_exh_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exh_q) |-> $past(done_i));

  assert_evt_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |=> !evt_q);

  assert_stall_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !stall_set_i) |=> !stall_q);
endmodule

// File: rtl/rxr_fetch.sv
module rxr_fetch
  import rxr_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int WORD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wide_mode,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [PTR_W-1:0]   cfg_wdata,
  input  logic               fetch_cmd,
  input  logic               stat_clr,
  input  logic               stall_set,
  output logic               mem_req,
  output logic [2*PTR_W-1:0] mem_addr,
  input  logic               mem_rvalid,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               busy,
  output logic [2*WORD_W-1:0] buf_addr,
  output logic [2*WORD_W-1:0] buf_wcnt,
  output logic [PTR_W-1:0]   ring_start,
  output logic [PTR_W-1:0]   ring_end,
  output logic [PTR_W-1:0]   ring_rd,
  output logic [PTR_W-1:0]   ring_wr,
  output logic [PTR_W-1:0]   ring_upper,
  output logic               exhausted,
  output logic               exhaust_evt,
  output logic               stall
);
  localparam int NW = ENTRY_WORDS;

  logic                 trig, done, hit;
  logic [NW*WORD_W-1:0] words;
  logic [2*WORD_W-1:0]  baddr_q, bcnt_q;

  assign trig = fetch_cmd | (stat_clr & exhausted);

  rxr_ptr_bank #(.PTR_W(PTR_W), .NWORDS(NW)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wide_i   (wide_mode),
    .wr_en_i  (cfg_we),
    .wr_sel_i (cfg_sel),
    .wr_data_i(cfg_wdata),
    .adv_i    (done),
    .start_o  (ring_start),
    .end_o    (ring_end),
    .rd_o     (ring_rd),
    .wr_o     (ring_wr),
    .upper_o  (ring_upper),
    .hit_o    (hit)
  );

  rxr_seq #(.PTR_W(PTR_W), .WORD_W(WORD_W), .NWORDS(NW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (trig),
    .wide_i  (wide_mode),
    .base_i  (ring_rd),
    .upper_i (ring_upper),
    .rvalid_i(mem_rvalid),
    .rdata_i (mem_rdata),
    .req_o   (mem_req),
    .addr_o  (mem_addr),
    .busy_o  (busy),
    .done_o  (done),
    .words_o (words)
  );

  rxr_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (done),
    .hit_i      (hit),
    .clr_i      (stat_clr),
    .stall_set_i(stall_set),
    .exh_o      (exhausted),
    .evt_o      (exhaust_evt),
    .stall_o    (stall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baddr_q <= '0;
      bcnt_q  <= '0;
    end else if (done) begin
      baddr_q <= words[2*WORD_W-1:0];
      bcnt_q  <= words[4*WORD_W-1:2*WORD_W];
    end
  end

  assign buf_addr = baddr_q;
  assign buf_wcnt = bcnt_q;

  assert_buf_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(buf_addr) && $stable(buf_wcnt)));
endmodule

// File: tb/rxr_fetch_tb.sv
`timescale 1ns/1ps
module rxr_fetch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        fetch_cmd = 1'b0;
  logic        stat_clr = 1'b0;
  logic        stall_set = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = 16'd0;
  logic        busy;
  logic [31:0] buf_addr, buf_wcnt;
  logic [15:0] ring_start, ring_end, ring_rd, ring_wr, ring_upper;
  logic        exhausted, exhaust_evt, stall;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rxr_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .fetch_cmd(fetch_cmd),
    .stat_clr(stat_clr), .stall_set(stall_set), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .buf_addr(buf_addr), .buf_wcnt(buf_wcnt),
    .ring_start(ring_start), .ring_end(ring_end), .ring_rd(ring_rd),
    .ring_wr(ring_wr), .ring_upper(ring_upper), .exhausted(exhausted),
    .exhaust_evt(exhaust_evt), .stall(stall)
  );

  function automatic logic [15:0] memf(input logic [31:0] a);
    return a[15:0] ^ {a[23:16], a[31:24]} ^ 16'h3C5A;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // memory responder with rotating latency
  bit pend = 0;
  int cnt = 0;
  int nresp = 0;
  logic [31:0] paddr;
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (pend) begin
      cnt--;
      if (cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata = memf(paddr);
        pend = 0;
      end
    end
    if (mem_req === 1'b1) begin
      pend = 1;
      cnt = 1 + (nresp % 3);
      paddr = mem_addr;
      nresp++;
    end
  end

  // behavioural reference model
  int          m_ph = 0;
  int          m_k = 0;
  logic [15:0] m_w [4];
  logic [15:0] m_start = 0, m_end = 0, m_rd = 0, m_wr = 0, m_up = 0;
  logic [31:0] m_ba = 0, m_bc = 0;
  bit          m_exh = 0, m_evt = 0, m_stall = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_k = 0; m_start = 0; m_end = 0; m_rd = 0; m_wr = 0; m_up = 0;
      m_ba = 0; m_bc = 0; m_exh = 0; m_evt = 0; m_stall = 0;
    end else begin
      bit trig, dn, old_exh;
      logic [15:0] nrd, msk;
      old_exh = m_exh;
      trig = fetch_cmd || (stat_clr && old_exh);
      dn = 0;
      if (m_ph == 0) begin
        if (trig) begin m_ph = 1; m_k = 0; end
      end else if (m_ph == 1) begin
        m_ph = 2;
      end else if (mem_rvalid) begin
        m_w[m_k] = mem_rdata;
        if (m_k == 3) begin dn = 1; m_ph = 0; end
        else begin m_k++; m_ph = 1; end
      end
      nrd = m_rd + (wide_mode ? 16'd16 : 16'd8);
      if (nrd == m_end) nrd = m_start;
      msk = wide_mode ? 16'hFFFC : 16'hFFFE;
      if (cfg_we) begin
        if (cfg_sel == 0) m_start = cfg_wdata & msk;
        if (cfg_sel == 1) m_end = cfg_wdata & msk;
        if (cfg_sel == 2) m_rd = cfg_wdata & msk;
        if (cfg_sel == 3) m_wr = cfg_wdata & msk;
        if (cfg_sel == 4) m_up = cfg_wdata;
      end
      m_evt = 0;
      if (stat_clr && old_exh) m_exh = 0;
      if (dn) begin
        m_rd = nrd;
        m_ba = {m_w[1], m_w[0]};
        m_bc = {m_w[3], m_w[2]};
        m_stall = 0;
        if (nrd == m_wr) begin m_exh = 1; m_evt = 1; end
      end
      if (stall_set) m_stall = 1;
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3 mem_req", {31'd0, mem_req}, {31'd0, m_ph == 1});
      if (m_ph == 1)
        chk("R3 mem_addr", mem_addr, {m_up, m_rd + 16'(m_k * (wide_mode ? 4 : 2))});
      chk("R8 busy", {31'd0, busy}, {31'd0, m_ph != 0});
      chk("R4 buf_addr", buf_addr, m_ba);
      chk("R4 buf_wcnt", buf_wcnt, m_bc);
      chk("R5 ring_rd", {16'd0, ring_rd}, {16'd0, m_rd});
      chk("R2 ring ptrs", {ring_start, ring_end}, {m_start, m_end});
      chk("R2 ring wr/up", {ring_wr, ring_upper}, {m_wr, m_up});
      chk("R7 exhausted", {30'd0, exhausted, exhaust_evt}, {30'd0, m_exh, m_evt});
      chk("R11 stall", {31'd0, stall}, {31'd0, m_stall});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog got=%0d exp=<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr_cfg(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse_fetch();
    @(negedge clk); fetch_cmd = 1;
    @(negedge clk); fetch_cmd = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); stat_clr = 1;
    @(negedge clk); stat_clr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic expect_entry(input string tag, input logic [15:0] up,
                              input logic [15:0] base, input int s);
    logic [15:0] w [4];
    for (int k = 0; k < 4; k++) w[k] = memf({up, base + 16'(k * s)});
    chk({tag, " R4 addr"}, buf_addr, {w[1], w[0]});
    chk({tag, " R4 count"}, buf_wcnt, {w[3], w[2]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy/req", {30'd0, busy, mem_req}, 32'd0);
    chk("R1 bufs", buf_addr | buf_wcnt, 32'd0);
    chk("R1 status", {29'd0, exhausted, exhaust_evt, stall}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ptrs", {ring_start, ring_rd}, 32'd0);

    // 16-bit mode setup, R2 masking
    wr_cfg(3'd4, 16'h0012);
    wr_cfg(3'd0, 16'h0101);
    chk("R2 start bit0 cleared", {16'd0, ring_start}, 32'h0100);
    chk("R2 upper unmasked", {16'd0, ring_upper}, 32'h0012);
    wr_cfg(3'd1, 16'h0118);
    wr_cfg(3'd2, 16'h0100);
    wr_cfg(3'd3, 16'h0100);

    // R3/R4/R5 first fetch
    pulse_fetch();
    chk("R8 busy after cmd", {31'd0, busy}, 32'd1);
    wait_idle();
    expect_entry("f1", 16'h0012, 16'h0100, 2);
    chk("R5 step 8", {16'd0, ring_rd}, 32'h0108);
    chk("R7 no exhaust", {31'd0, exhausted}, 32'd0);
    pulse_fetch(); wait_idle();
    chk("R5 step 8 again", {16'd0, ring_rd}, 32'h0110);

    // R6 wrap and R7 exhaustion
    pulse_fetch(); wait_idle();
    expect_entry("f3", 16'h0012, 16'h0110, 2);
    chk("R6 wrap to start", {16'd0, ring_rd}, 32'h0100);
    @(negedge clk);
    chk("R7 exhausted set", {31'd0, exhausted}, 32'd1);

    // R9 clear with status high fetches
    pulse_clr();
    chk("R9 status cleared", {31'd0, exhausted}, 32'd0);
    chk("R9 fetch started", {31'd0, busy}, 32'd1);
    wait_idle();
    chk("R9 fetch done", {16'd0, ring_rd}, 32'h0108);
    pulse_clr();
    chk("R9 clear while low no fetch", {31'd0, busy}, 32'd0);
    chk("R9 rd unchanged", {16'd0, ring_rd}, 32'h0108);

    // R10 triggers while busy ignored
    pulse_fetch();
    @(negedge clk); fetch_cmd = 1; stat_clr = 1;
    @(negedge clk); fetch_cmd = 0; stat_clr = 0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R10 no extra fetch", {31'd0, busy}, 32'd0);
    chk("R10 single step", {16'd0, ring_rd}, 32'h0110);

    // R11 stall flag
    @(negedge clk); stall_set = 1;
    @(negedge clk); stall_set = 0;
    chk("R11 stall set", {31'd0, stall}, 32'd1);
    pulse_fetch(); wait_idle();
    chk("R11 stall cleared", {31'd0, stall}, 32'd0);

    // 32-bit mode
    @(negedge clk); wide_mode = 1;
    wr_cfg(3'd4, 16'hBEEF);
    wr_cfg(3'd0, 16'h0203);
    wr_cfg(3'd1, 16'h0233);
    wr_cfg(3'd2, 16'h0222);
    wr_cfg(3'd3, 16'h0202);
    chk("R2 wide mask start", {16'd0, ring_start}, 32'h0200);
    chk("R2 wide mask rd", {16'd0, ring_rd}, 32'h0220);
    wr_cfg(3'd5, 16'h7777);
    chk("R2 unused select", {ring_start, ring_end}, 32'h02000230);
    chk("R2 unused select wr", {ring_wr, ring_rd}, 32'h02000220);
    pulse_fetch(); wait_idle();
    expect_entry("w1", 16'hBEEF, 16'h0220, 4);
    chk("R6 wide wrap", {16'd0, ring_rd}, 32'h0200);
    @(negedge clk);
    chk("R7 wide exhausted", {31'd0, exhausted}, 32'd1);
    pulse_clr(); wait_idle();
    chk("R5 step 16", {16'd0, ring_rd}, 32'h0210);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule